// File: doc/BRIEF.md
# GPIO Pull Resistor Sequencer

This block holds the pull-resistor setting of every GPIO pin and drives two registered enable vectors, one for the pull-up and one for the pull-down of each pad. Software reaches it through a single-cycle write port. A build-time parameter selects one of two register models.

In the sequenced model, software first writes the desired pull mode into one shared mode register. It then waits a settling interval and writes a per-bank strobe mask in which a 1 marks each pin that should take that mode. Finally it clears both registers. A pin takes the shared mode only when its mask bit rises and the mode has been left untouched for at least `SETTLE_CYCLES` clocks. Every other pin keeps its setting.

In the direct model, each pin owns a 2-bit code packed sixteen to a word. A write loads those codes at once. The two models share the three states (off, pull-down and pull-up) but encode them differently.

Top module: `pull_seq`

## Requirements
- R1: During reset and right after it, every pin is off: `pull_up` and `pull_dn` are all zero, in both models.
- R2: Sequenced model: address 0 is the shared mode register and takes `wr_data[1:0]`. Code 0 means off, 1 pull-down, 2 pull-up and 3 off.
- R3: Sequenced model: a write to address 1+b stores the strobe mask of bank b, which covers pins 32*b to 32*b+31 with bit i for pin 32*b+i. Each mask bit that goes from 0 to 1 loads the stored mode into its pin, and the outputs change at the clock edge of that write.
- R4: A pin whose mask bit does not rise keeps its previous state. Mask bits above `NUM_PINS`-1 have no effect.
- R5: A rising mask bit loads only if at least `SETTLE_CYCLES` clock cycles with no mode write lie between the last mode write and the mask write. Otherwise the load is dropped, although the mask value is still stored.
- R6: A mask bit that is already 1 and is written as 1 again does not reload its pin, even if the mode has changed.
- R7: Writing the mode register, or writing a zero mask, never changes any pin state. Clearing both registers after a sequence therefore leaves the loaded states in place.
- R8: Direct model: address w holds pins 16*w to 16*w+15, with pin p at bits `2*(p%16)+1:2*(p%16)`. Code 0 means off, 1 pull-up, 2 pull-down and 3 off. All pins in the word load at the edge of the write, with no settling delay.
- R9: Writes to unmapped addresses are ignored. In the sequenced model these are addresses above `NUM_BANKS`; in the direct model they are addresses at or above `NUM_WORDS`.
- R10: No pin ever has its pull-up and pull-down enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Write data |
| pull_up | output | NUM_PINS | Registered pull-up enable per pin |
| pull_dn | output | NUM_PINS | Registered pull-down enable per pin |

## Verification
The hardest case to reach from the ports is a mask edge that is rejected. There are two ways this happens: the mode was rewritten too recently, or the mask bit is already high from an earlier write that was never cleared. The stimulus table sweeps the gap between the mode write and the mask write on both sides of the settling limit, at exactly the limit and one cycle short. A directed sequence then leaves a mask bit high, changes the mode, and writes the mask again, so that only a freshly rising neighbouring bit takes the new mode.

// File: rtl/pull_seq_pkg.sv
`timescale 1ns/1ps
package pull_seq_pkg;

  typedef struct packed {
    logic up;
    logic dn;
  } pull_t;

  // sequenced model codes
  localparam logic [1:0] SEQ_DOWN = 2'd1;
  localparam logic [1:0] SEQ_UP   = 2'd2;
  // direct model codes
  localparam logic [1:0] DIR_UP   = 2'd1;
  localparam logic [1:0] DIR_DOWN = 2'd2;

  function automatic pull_t seq_decode(input logic [1:0] code);
    pull_t r;
    r.up = (code == SEQ_UP);
    r.dn = (code == SEQ_DOWN);
    return r;
  endfunction

  function automatic pull_t dir_decode(input logic [1:0] code);
    pull_t r;
    r.up = (code == DIR_UP);
    r.dn = (code == DIR_DOWN);
    return r;
  endfunction

endpackage

// File: rtl/pull_settle_timer.sv
`timescale 1ns/1ps
module pull_settle_timer #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic settled
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (restart)      cnt_q <= '0;
    else if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign settled = (cnt_q >= LIMIT);
endmodule

// File: rtl/pull_seq_ctrl.sv
`timescale 1ns/1ps
module pull_seq_ctrl
  import pull_seq_pkg::*;
#(
  parameter int NUM_PINS      = 40,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 4,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_PINS-1:0] load,
  output logic [NUM_PINS-1:0] nu_up,
  output logic [NUM_PINS-1:0] nu_dn
);
  localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;

  logic [1:0]           mode_q;
  logic [NUM_PINS-1:0]  mask_q;
  logic [NUM_BANKS-1:0] bank_hit;
  logic                 mode_wr;
  logic                 settled;
  pull_t                mode_pull;

  assign mode_wr = wr_en && (wr_addr == '0);

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_wr) mode_q <= wr_data[1:0];
  end

  pull_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (mode_wr),
    .settled (settled)
  );

  assign mode_pull = seq_decode(mode_q);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = wr_en && (wr_addr == ADDR_W'(b + 1));
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int B = p / DATA_W;
    localparam int I = p % DATA_W;

    always_ff @(posedge clk) begin
      if (rst)              mask_q[p] <= 1'b0;
      else if (bank_hit[B]) mask_q[p] <= wr_data[I];
    end

    assign load[p]  = bank_hit[B] && settled && wr_data[I] && !mask_q[p];
    assign nu_up[p] = mode_pull.up;
    assign nu_dn[p] = mode_pull.dn;
  end
endmodule

// File: rtl/pull_dir_ctrl.sv
`timescale 1ns/1ps
module pull_dir_ctrl
  import pull_seq_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_PINS-1:0] load,
  output logic [NUM_PINS-1:0] nu_up,
  output logic [NUM_PINS-1:0] nu_dn
);
  localparam int FPW = DATA_W / 2;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int W = p / FPW;
    localparam int F = p % FPW;
    pull_t code_pull;

    assign code_pull = dir_decode(wr_data[2*F +: 2]);
    assign load[p]   = wr_en && (wr_addr == ADDR_W'(W));
    assign nu_up[p]  = code_pull.up;
    assign nu_dn[p]  = code_pull.dn;
  end
endmodule

// File: rtl/pull_seq.sv
`timescale 1ns/1ps
module pull_seq #(
  parameter int NUM_PINS      = 40,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 4,
  parameter int SETTLE_CYCLES = 4,
  parameter bit USE_SEQ       = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_PINS-1:0] pull_up,
  output logic [NUM_PINS-1:0] pull_dn
);
  localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int NUM_WORDS = (NUM_PINS + DATA_W/2 - 1) / (DATA_W/2);

  logic [NUM_PINS-1:0] load, nu_up, nu_dn;
  logic [NUM_PINS-1:0] pu_q, pd_q;

  if (USE_SEQ) begin : g_seq
    pull_seq_ctrl #(
      .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_ctrl (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .load(load), .nu_up(nu_up), .nu_dn(nu_dn)
    );
  end else begin : g_dir
    pull_dir_ctrl #(
      .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_ctrl (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .load(load), .nu_up(nu_up), .nu_dn(nu_dn)
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pu_q <= '0;
      pd_q <= '0;
    end else begin
      pu_q <= (pu_q & ~load) | (nu_up & load);
      pd_q <= (pd_q & ~load) | (nu_dn & load);
    end
  end

  assign pull_up = pu_q;
  assign pull_dn = pd_q;
endmodule

// File: rtl/pull_seq_chk.sv
`timescale 1ns/1ps
module pull_seq_chk #(
  parameter int NUM_PINS  = 40,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter bit USE_SEQ   = 1'b1,
  parameter int NUM_BANKS = 2,
  parameter int NUM_WORDS = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic [NUM_PINS-1:0] pull_up,
  input logic [NUM_PINS-1:0] pull_dn
);
  localparam int LAST_ADDR = USE_SEQ ? NUM_BANKS : NUM_WORDS - 1;

  // R10: pull-up and pull-down never both enabled on one pin
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    (pull_up & pull_dn) == '0);

  // R1: first cycle after reset shows all pins off
  p_reset_off_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pull_up == '0 && pull_dn == '0));

  // R9: unmapped addresses leave every pin alone
  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > ADDR_W'(LAST_ADDR)) |=> ($stable(pull_up) && $stable(pull_dn)));

  // R7: without a write nothing moves
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(pull_up) && $stable(pull_dn)));

  // R7: sequenced model, mode writes and zero masks never change pin state
  p_clear_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (USE_SEQ && wr_en && (wr_addr == '0 || wr_data == '0))
      |=> ($stable(pull_up) && $stable(pull_dn)));
endmodule

bind pull_seq pull_seq_chk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .USE_SEQ(USE_SEQ), .NUM_BANKS(NUM_BANKS), .NUM_WORDS(NUM_WORDS)
) u_chk (.*);

// File: tb/pull_seq_tb.sv
`timescale 1ns/1ps
module pull_seq_tb;
  localparam int NP = 40;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int ST = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en_s = 1'b0, wr_en_d = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NP-1:0] up_s, dn_s, up_d, dn_d;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pull_seq #(.NUM_PINS(NP), .DATA_W(DW), .ADDR_W(AW), .SETTLE_CYCLES(ST), .USE_SEQ(1'b1)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en_s), .wr_addr(wr_addr), .wr_data(wr_data),
    .pull_up(up_s), .pull_dn(dn_s));

  pull_seq #(.NUM_PINS(NP), .DATA_W(DW), .ADDR_W(AW), .SETTLE_CYCLES(ST), .USE_SEQ(1'b0)) u_dut_direct (
    .clk(clk), .rst(rst), .wr_en(wr_en_d), .wr_addr(wr_addr), .wr_data(wr_data),
    .pull_up(up_d), .pull_dn(dn_d));

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  gap;
    logic        bank;
    logic [31:0] mask;
    logic [31:0] eup;
    logic [31:0] edn;
  } row_t;

  // sequenced model: mode, idle gap, bank, mask, expected bank up / down
  localparam row_t ROWS [7] = '{
    '{2'd2, 4'd4, 1'b0, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000},
    '{2'd1, 4'd4, 1'b0, 32'h0000_0F0F, 32'h0000_00F0, 32'h0000_0F0F},
    '{2'd2, 4'd3, 1'b0, 32'hFFFF_0000, 32'h0000_00F0, 32'h0000_0F0F},
    '{2'd1, 4'd6, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_00FF},
    '{2'd0, 4'd4, 1'b0, 32'h0000_0003, 32'h0000_00F0, 32'h0000_0F0C},
    '{2'd3, 4'd5, 1'b1, 32'h0000_000F, 32'h0000_0000, 32'h0000_00F0},
    '{2'd2, 4'd4, 1'b1, 32'h0000_0081, 32'h0000_0081, 32'h0000_0070}
  };

  function automatic logic [31:0] bank_of(input logic [NP-1:0] v, input logic b);
    return b ? {24'h0, v[39:32]} : v[31:0];
  endfunction

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_s(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en_s = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en_s = 1'b0;
  endtask

  task automatic wr_d(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en_d = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en_d = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic seq_load(input logic [1:0] mode, input int gap, input logic bank, input logic [31:0] mask);
    wr_s('0, {30'h0, mode});
    idle(gap);
    wr_s(AW'(1 + bank), mask);
    wr_s(AW'(1 + bank), '0);
    wr_s('0, '0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 reset seq up", 40'(up_s), 40'h0);
    check("R1 reset seq dn", 40'(dn_s), 40'h0);
    rst = 1'b0;
    idle(2);
    check("R1 after reset dir up/dn", 40'(up_d | dn_d), 40'h0);

    // R2 R3 R4 R5 R7: table of sequenced loads
    for (int i = 0; i < 7; i++) begin
      seq_load(ROWS[i].mode, int'(ROWS[i].gap), ROWS[i].bank, ROWS[i].mask);
      check($sformatf("R2/R3/R4/R5 row %0d up", i), 40'(bank_of(up_s, ROWS[i].bank)), 40'(ROWS[i].eup));
      check($sformatf("R2/R3/R4/R5 row %0d dn", i), 40'(bank_of(dn_s, ROWS[i].bank)), 40'(ROWS[i].edn));
    end
    check("R4 bank0 untouched by bank1 rows up", 40'(up_s[31:0]), 40'h0000_00F0);

    // R6: held mask bit does not reload
    wr_s('0, 32'd2); idle(ST);
    wr_s(AW'(1), 32'h1);
    check("R3 pin0 up", 40'(up_s[31:0]), 40'h0000_00F1);
    wr_s('0, 32'd1); idle(ST);
    wr_s(AW'(1), 32'h1);
    check("R6 held bit up", 40'(up_s[31:0]), 40'h0000_00F1);
    check("R6 held bit dn", 40'(dn_s[31:0]), 40'h0000_0F0C);
    wr_s(AW'(1), 32'h3);
    check("R6 neighbour rises dn", 40'(dn_s[31:0]), 40'h0000_0F0E);
    check("R6 neighbour rises up", 40'(up_s[31:0]), 40'h0000_00F1);
    wr_s(AW'(1), '0);
    wr_s('0, '0);
    check("R7 clear keeps up", 40'(up_s), {8'h81, 32'h0000_00F1});
    check("R7 clear keeps dn", 40'(dn_s), {8'h70, 32'h0000_0F0E});

    // R9: unmapped addresses, sequenced model
    wr_s('0, 32'd2); idle(ST);
    wr_s(AW'(3), 32'hFFFF_FFFF);
    wr_s(AW'(15), 32'hFFFF_FFFF);
    check("R9 seq unmapped up", 40'(up_s), {8'h81, 32'h0000_00F1});
    check("R9 seq unmapped dn", 40'(dn_s), {8'h70, 32'h0000_0F0E});
    check("R10 seq exclusive", 40'(up_s & dn_s), 40'h0);

    // R8: direct model
    wr_d('0, 32'hAAAA_AA39);
    check("R8 word0 up", 40'(up_d), 40'h00_0000_0001);
    check("R8 word0 dn", 40'(dn_d), 40'h00_0000_FFF2);
    wr_d(AW'(1), 32'h5555_AAAA);
    check("R8 word1 up", 40'(up_d), 40'h00_FF00_0001);
    check("R8 word1 dn", 40'(dn_d), 40'h00_00FF_FFF2);
    wr_d(AW'(2), 32'hFFFF_5555);
    check("R8 word2 partial up", 40'(up_d), 40'hFF_FF00_0001);
    check("R8 word2 partial dn", 40'(dn_d), 40'h00_00FF_FFF2);
    wr_d(AW'(3), 32'h5555_5555);
    check("R9 dir unmapped up", 40'(up_d), 40'hFF_FF00_0001);
    check("R9 dir unmapped dn", 40'(dn_d), 40'h00_00FF_FFF2);
    wr_d('0, 32'h0);
    check("R8 word0 cleared up", 40'(up_d), 40'hFF_FF00_0000);
    check("R8 word0 cleared dn", 40'(dn_d), 40'h00_00FF_0000);
    check("R10 dir exclusive", 40'(up_d & dn_d), 40'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule